// File: doc/BRIEF.md
# Highly Associative Data Cache Controller

This block is a 16 KB data cache that sits between a 32-bit core port and a word-wide memory port. A core request is held until the cache answers it with a one-cycle ready pulse. The cache looks up the tag, serves hits from its own storage, and on a miss fetches the whole 8-word line from memory in a burst. When the chosen victim line holds modified data, the cache first writes that data back to memory.

The storage is organised as 8 sets of 64 ways, with 8 words of 32 bits per line. Each line has a valid bit and two dirty bits, one for each 4-word half. On eviction only the modified halves are written back. One mode input selects the write policy. With `wt_mode` high the cache is write-through: writes go to memory, and a write miss does not allocate a line. With `wt_mode` low it is write-back. A second input chooses how the victim is picked: a round-robin pointer kept for each set, or a free-running pseudo-random sequence.

All addresses are 32-bit word addresses. Bits [2:0] select the word in the line, bits [5:3] select the set, and bits [29:6] form the tag. Core writes always update a whole word.

Top module: `cache_ctrl`

## Requirements
- R1: After a synchronous reset, `core_ready` and `mem_req` are low and every line is invalid, so the first access to any address misses.
- R2: A read miss with a clean victim reads the line from memory as 8 single-word beats with `mem_we` low. The beats go in ascending order from word 0 of the line, and the requested word is returned.
- R3: A read hit returns the stored word without any memory traffic. A lookup never matches more than one way.
- R4: In write-back mode a write hit updates only the line and issues no memory write. It sets the dirty bit of the half that holds the word, where word-address bit 2 selects the half. A write miss first allocates the line.
- R5: A victim with dirty halves is written back before the fill. Each dirty half is written as 4 ascending words at the victim's own address, and a clean half is skipped.
- R6: In write-through mode a write hit updates the line and issues exactly one memory write of that word, and it leaves the line clean, so a later eviction writes nothing back.
- R7: In write-through mode a write miss issues exactly one memory write, performs no fill and allocates nothing, so the next read of that address misses.
- R8: In round-robin mode each set has its own pointer. The pointer starts at way 0 and advances by one on every fill in that set, so the 65th distinct line filled into a set evicts the first.
- R9: In pseudo-random mode the victim way comes from a free-running sequence. All data stays correct, and filling 65 distinct lines into one set evicts at least one of them.
- R10: `mem_req`, `mem_we` and `mem_waddr` stay unchanged while a memory beat waits for `mem_ack`.
- R11: `core_ready` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back |
| rand_mode | input | 1 | 1 = pseudo-random victim, 0 = round-robin |
| core_req | input | 1 | Core request, held until `core_ready` |
| core_we | input | 1 | 1 = write, 0 = read |
| core_waddr | input | 30 | Core word address |
| core_wdata | input | 32 | Core write data |
| core_ready | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Read data, valid with `core_ready` |
| mem_req | output | 1 | Memory beat request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write beat |
| mem_waddr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the beat; read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Several properties are checked on every cycle. At most one way matches a lookup. `core_ready` never stays high for two cycles. A pending memory beat holds its request, direction and address. Fill beats are always reads. A write-back write hit is not followed by a memory request, and a write-through write miss is followed at once by a memory write. Other behaviour shows up only in the bench's directed scenarios. These cover the ordering and count of fill and write-back beats, whether a half is skipped, which line a round-robin pointer evicts after 64 fills into one set, that each set keeps its own pointer, and that a write-through line really stays clean until it is evicted.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RDOUT,
    ST_WTWR,
    ST_WBRD,
    ST_WBGO,
    ST_WBWAIT,
    ST_FILL
  } ctl_state_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int NSETS = 8,
  parameter int NWAYS = 64,
  parameter int TAG_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NSETS)-1:0] set_idx,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     hit,
  output logic [$clog2(NWAYS)-1:0] hit_way,
  input  logic [$clog2(NWAYS)-1:0] vic_way,
  output logic [TAG_W-1:0]         vic_tag,
  output logic [1:0]               vic_dirty,
  input  logic                     fill_en,
  input  logic [$clog2(NWAYS)-1:0] fill_way,
  input  logic                     dirty_en,
  input  logic [$clog2(NWAYS)-1:0] dirty_way,
  input  logic                     dirty_half
);
  localparam int WAY_W = $clog2(NWAYS);

  logic [TAG_W-1:0] tag_q [NSETS][NWAYS];
  logic [NWAYS-1:0] val_q [NSETS];
  logic [1:0]       drt_q [NSETS][NWAYS];
  logic [NWAYS-1:0] match;

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign match[w] = val_q[set_idx][w] && (tag_q[set_idx][w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end
  assign hit       = |match;
  assign vic_tag   = tag_q[set_idx][vic_way];
  assign vic_dirty = drt_q[set_idx][vic_way] & {2{val_q[set_idx][vic_way]}};

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[set_idx][fill_way] <= lk_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) begin
        val_q[s] <= '0;
        for (int w = 0; w < NWAYS; w++) drt_q[s][w] <= 2'b00;
      end
    end else begin
      if (fill_en) begin
        val_q[set_idx][fill_way] <= 1'b1;
        drt_q[set_idx][fill_way] <= 2'b00;
      end
      if (dirty_en) drt_q[set_idx][dirty_way][dirty_half] <= 1'b1;
    end
  end

  p_one_way_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(match))
    else $error("R3: lookup matched several ways");
endmodule

// File: rtl/cache_data_ram.sv
module cache_data_ram #(
  parameter int DEPTH = 4096,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int NSETS = 8,
  parameter int NWAYS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rand_mode,
  input  logic [$clog2(NSETS)-1:0] set_idx,
  input  logic                     adv,
  output logic [$clog2(NWAYS)-1:0] way
);
  localparam int WAY_W = $clog2(NWAYS);

  logic [WAY_W-1:0] rr_q [NSETS];
  logic [15:0]      lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= 16'hACE1;
      for (int s = 0; s < NSETS; s++) rr_q[s] <= '0;
    end else begin
      lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
      if (adv) rr_q[set_idx] <= rr_q[set_idx] + WAY_W'(1);
    end
  end

  assign way = rand_mode ? lfsr_q[WAY_W-1:0] : rr_q[set_idx];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int NSETS      = 8,
  parameter int NWAYS      = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wt_mode,
  input  logic        rand_mode,
  input  logic        core_req,
  input  logic        core_we,
  input  logic [29:0] core_waddr,
  input  logic [31:0] core_wdata,
  output logic        core_ready,
  output logic [31:0] core_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [29:0] mem_waddr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NSETS);
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int TAG_W  = 30 - IDX_W - WSEL_W;
  localparam int HALF   = LINE_WORDS / 2;
  localparam int RA_W   = IDX_W + WAY_W + WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(LINE_WORDS - 1);
  localparam logic [WSEL_W-1:0] HALF_E = WSEL_W'(HALF - 1);
  localparam logic [WSEL_W-1:0] HALF_S = WSEL_W'(HALF);

  ctl_state_t        state;
  logic [29:0]       a_addr;
  logic              a_we;
  logic [31:0]       a_wdata;
  logic [WSEL_W-1:0] cnt;
  logic [WAY_W-1:0]  vway;
  logic [TAG_W-1:0]  vtag;
  logic [1:0]        vdirty;

  logic [WSEL_W-1:0] a_word;
  logic [IDX_W-1:0]  a_set;
  logic [TAG_W-1:0]  a_tag;
  assign a_word = a_addr[WSEL_W-1:0];
  assign a_set  = a_addr[WSEL_W +: IDX_W];
  assign a_tag  = a_addr[29 -: TAG_W];

  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic [TAG_W-1:0] vic_tag;
  logic [1:0]       vic_dirty;
  logic             fill_done, dirty_en, wb_last;
  logic             ram_we;
  logic [RA_W-1:0]  ram_addr;
  logic [31:0]      ram_wd, ram_rd;

  assign fill_done = (state == ST_FILL) && mem_ack && (cnt == LAST_W);
  assign dirty_en  = (state == ST_LOOK) && hit && a_we && !wt_mode;
  assign wb_last   = (cnt == LAST_W) || ((cnt == HALF_E) && !vdirty[1]);

  cache_tag_store #(.NSETS(NSETS), .NWAYS(NWAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .set_idx(a_set), .lk_tag(a_tag),
    .hit(hit), .hit_way(hit_way),
    .vic_way(vic_way), .vic_tag(vic_tag), .vic_dirty(vic_dirty),
    .fill_en(fill_done), .fill_way(vway),
    .dirty_en(dirty_en), .dirty_way(hit_way), .dirty_half(a_word[WSEL_W-1])
  );

  cache_victim_sel #(.NSETS(NSETS), .NWAYS(NWAYS)) u_vic (
    .clk(clk), .rst(rst), .rand_mode(rand_mode), .set_idx(a_set),
    .adv(fill_done), .way(vic_way)
  );

  cache_data_ram #(.DEPTH(NSETS * NWAYS * LINE_WORDS), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wd), .rdata(ram_rd)
  );

  always_comb begin
    ram_addr = {a_set, vway, cnt};
    ram_we   = 1'b0;
    ram_wd   = a_wdata;
    case (state)
      ST_LOOK: begin
        ram_addr = {a_set, hit_way, a_word};
        ram_we   = hit && a_we;
      end
      ST_FILL: begin
        ram_we = mem_ack;
        ram_wd = mem_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      a_addr     <= '0;
      a_we       <= 1'b0;
      a_wdata    <= '0;
      cnt        <= '0;
      vway       <= '0;
      vtag       <= '0;
      vdirty     <= 2'b00;
      core_ready <= 1'b0;
      core_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
    end else begin
      core_ready <= 1'b0;
      case (state)
        ST_IDLE: if (core_req) begin
          a_addr  <= core_waddr;
          a_we    <= core_we;
          a_wdata <= core_wdata;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit && !a_we) begin
            state <= ST_RDOUT;
          end else if (a_we && wt_mode) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_waddr <= a_addr;
            mem_wdata <= a_wdata;
            state     <= ST_WTWR;
          end else if (hit) begin
            core_ready <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            vway   <= vic_way;
            vtag   <= vic_tag;
            vdirty <= vic_dirty;
            if (|vic_dirty) begin
              cnt   <= vic_dirty[0] ? '0 : HALF_S;
              state <= ST_WBRD;
            end else begin
              cnt       <= '0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b0;
              mem_waddr <= {a_tag, a_set, {WSEL_W{1'b0}}};
              state     <= ST_FILL;
            end
          end
        end
        ST_RDOUT: begin
          core_rdata <= ram_rd;
          core_ready <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_WTWR: if (mem_ack) begin
          mem_req    <= 1'b0;
          mem_we     <= 1'b0;
          core_ready <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_WBRD: state <= ST_WBGO;
        ST_WBGO: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_waddr <= {vtag, a_set, cnt};
          mem_wdata <= ram_rd;
          state     <= ST_WBWAIT;
        end
        ST_WBWAIT: if (mem_ack) begin
          mem_we <= 1'b0;
          if (wb_last) begin
            cnt       <= '0;
            mem_req   <= 1'b1;
            mem_waddr <= {a_tag, a_set, {WSEL_W{1'b0}}};
            state     <= ST_FILL;
          end else begin
            mem_req <= 1'b0;
            cnt     <= cnt + WSEL_W'(1);
            state   <= ST_WBRD;
          end
        end
        ST_FILL: if (mem_ack) begin
          if (cnt == LAST_W) begin
            mem_req <= 1'b0;
            state   <= ST_LOOK;
          end else begin
            cnt       <= cnt + WSEL_W'(1);
            mem_waddr <= {a_tag, a_set, cnt + WSEL_W'(1)};
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_waddr)))
    else $error("R10: memory beat changed before ack");
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    core_ready |=> !core_ready)
    else $error("R11: ready longer than one cycle");
  p_fill_reads_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && mem_req) |-> !mem_we)
    else $error("R2: fill beat is a write");
  p_wb_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && hit && a_we && !wt_mode) |=> !mem_req)
    else $error("R4: write-back hit touched memory");
  p_wt_nofill_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && !hit && a_we && wt_mode) |=> (mem_req && mem_we))
    else $error("R7: write-through miss did not write memory");
endmodule

// File: tb/cache_ctrl_test.sv
module cache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wt_mode = 1'b0, rand_mode = 1'b0;
  logic        core_req = 1'b0, core_we = 1'b0;
  logic [29:0] core_waddr = '0;
  logic [31:0] core_wdata = '0;
  logic        core_ready;
  logic [31:0] core_rdata;
  logic        mem_req, mem_we;
  logic [29:0] mem_waddr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, hold_bad = 0, pulse_bad = 0;
  logic [29:0] rlog [16];
  logic [29:0] wlog [16];
  logic [31:0] store [logic [29:0]];

  always #2 clk = ~clk;

  cache_ctrl uut (
    .clk(clk), .rst(rst), .wt_mode(wt_mode), .rand_mode(rand_mode),
    .core_req(core_req), .core_we(core_we), .core_waddr(core_waddr),
    .core_wdata(core_wdata), .core_ready(core_ready), .core_rdata(core_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mval(logic [29:0] a);
    if (store.exists(a)) return store[a];
    return {2'b00, a} ^ 32'h5A00_0000;
  endfunction

  function automatic logic [29:0] line(int tag, int set);
    return 30'((tag << 6) | (set << 3));
  endfunction

  // memory model: one ack per beat, answered at the falling edge
  initial begin
    logic        pend = 1'b0;
    logic [29:0] pa = '0;
    forever begin
      @(negedge clk);
      if (pend && mem_req && !mem_ack && mem_waddr != pa) hold_bad++;
      if (mem_ack) begin
        mem_ack = 1'b0;
        pend = 1'b0;
      end else if (mem_req) begin
        if (!pend) begin
          pend = 1'b1;
          pa = mem_waddr;
        end else begin
          mem_ack = 1'b1;
          if (mem_we) begin
            store[mem_waddr] = mem_wdata;
            wlog[wr_cnt % 16] = mem_waddr;
            wr_cnt++;
          end else begin
            mem_rdata = mval(mem_waddr);
            rlog[rd_cnt % 16] = mem_waddr;
            rd_cnt++;
          end
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish act=%0d exp=done", 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [29:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    core_req = 1'b1; core_we = we; core_waddr = a; core_wdata = d;
    do @(negedge clk); while (!core_ready);
    q = core_rdata;
    core_req = 1'b0;
    @(negedge clk);
    if (core_ready) pulse_bad++;
  endtask

  task automatic rd(input logic [29:0] a, output logic [31:0] q);
    access(1'b0, a, '0, q);
  endtask

  task automatic wr(input logic [29:0] a, input logic [31:0] d);
    logic [31:0] q;
    access(1'b1, a, d, q);
  endtask

  task automatic fill_set(input int set, input int t0, input int t1);
    logic [31:0] q;
    for (int t = t0; t <= t1; t++) rd(line(t, set), q);
  endtask

  task automatic t_reset;
    chk(core_ready == 1'b0, "R1 ready after reset", 32'(core_ready), 0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_read_miss_hit;
    logic [31:0] q;
    int r0;
    r0 = rd_cnt;
    rd(30'h43, q);
    chk(rd_cnt - r0 == 8, "R1/R2 miss beat count", 32'(rd_cnt - r0), 8);
    chk(rlog[r0 % 16] == 30'h40, "R2 first beat addr", 32'(rlog[r0 % 16]), 32'h40);
    chk(rlog[(r0 + 7) % 16] == 30'h47, "R2 last beat addr", 32'(rlog[(r0 + 7) % 16]), 32'h47);
    chk(q == mval(30'h43), "R2 miss data", q, mval(30'h43));
    r0 = rd_cnt;
    rd(30'h41, q);
    chk(rd_cnt == r0 && q == mval(30'h41), "R3 hit data, no traffic", q, mval(30'h41));
  endtask

  task automatic t_wb_write;
    logic [31:0] q;
    int w0;
    int r0;
    wt_mode = 1'b0;
    w0 = wr_cnt;
    wr(30'h42, 32'hDEAD_BEEF);
    chk(wr_cnt == w0, "R4 no memory write on hit", 32'(wr_cnt - w0), 0);
    r0 = rd_cnt;
    rd(30'h42, q);
    chk(q == 32'hDEAD_BEEF && rd_cnt == r0, "R4 line updated", q, 32'hDEAD_BEEF);
  endtask

  task automatic t_evict_low_rr;
    logic [31:0] q;
    int w0;
    int r0;
    fill_set(0, 2, 64);
    w0 = wr_cnt;
    rd(line(65, 0), q);
    chk(wr_cnt - w0 == 4, "R5 low half writeback count", 32'(wr_cnt - w0), 4);
    chk(wlog[w0 % 16] == 30'h40 && wlog[(w0 + 3) % 16] == 30'h43, "R5 writeback addrs",
        32'(wlog[w0 % 16]), 32'h40);
    chk(store[30'h42] == 32'hDEAD_BEEF, "R5 dirty word reached memory", store[30'h42], 32'hDEAD_BEEF);
    r0 = rd_cnt;
    rd(line(2, 0), q);
    chk(rd_cnt == r0, "R8 way 1 survived first eviction", 32'(rd_cnt - r0), 0);
    w0 = wr_cnt; r0 = rd_cnt;
    rd(line(66, 0), q);
    chk(wr_cnt == w0 && rd_cnt - r0 == 8, "R8 next fill evicts clean way 1", 32'(wr_cnt - w0), 0);
    r0 = rd_cnt;
    rd(line(2, 0), q);
    chk(rd_cnt - r0 == 8, "R8 tag 2 was evicted", 32'(rd_cnt - r0), 8);
  endtask

  task automatic t_evict_high;
    int w0;
    int r0;
    logic [31:0] q;
    logic [29:0] a;
    a = line(1, 1) + 30'd5;
    r0 = rd_cnt; w0 = wr_cnt;
    wr(a, 32'h1234_5678);
    chk(rd_cnt - r0 == 8 && wr_cnt == w0, "R4 write miss allocates", 32'(rd_cnt - r0), 8);
    fill_set(1, 2, 64);
    w0 = wr_cnt;
    rd(line(65, 1), q);
    chk(wr_cnt - w0 == 4, "R5 high half count (R8 own set pointer)", 32'(wr_cnt - w0), 4);
    chk(wlog[w0 % 16] == line(1, 1) + 30'd4, "R5 high half start", 32'(wlog[w0 % 16]),
        32'(line(1, 1) + 30'd4));
    chk(store[a] == 32'h1234_5678, "R5 high word in memory", store[a], 32'h1234_5678);
  endtask

  task automatic t_wt;
    logic [31:0] q;
    int w0;
    int r0;
    logic [29:0] a;
    wt_mode = 1'b1;
    a = line(1, 2) + 30'd2;
    rd(line(1, 2), q);
    w0 = wr_cnt; r0 = rd_cnt;
    wr(a, 32'hCAFE_0001);
    chk(wr_cnt - w0 == 1 && rd_cnt == r0, "R6 one write, no fill", 32'(wr_cnt - w0), 1);
    chk(wlog[w0 % 16] == a && store[a] == 32'hCAFE_0001, "R6 memory updated", store[a], 32'hCAFE_0001);
    rd(a, q);
    chk(q == 32'hCAFE_0001 && rd_cnt == r0, "R6 line updated", q, 32'hCAFE_0001);
    fill_set(2, 2, 64);
    w0 = wr_cnt;
    rd(line(65, 2), q);
    chk(wr_cnt == w0, "R6 clean eviction", 32'(wr_cnt - w0), 0);
    a = line(1, 3) + 30'd3;
    w0 = wr_cnt; r0 = rd_cnt;
    wr(a, 32'h0000_B00B);
    chk(wr_cnt - w0 == 1 && rd_cnt == r0, "R7 write miss single write", 32'(rd_cnt - r0), 0);
    rd(a, q);
    chk(rd_cnt - r0 == 8 && q == 32'h0000_B00B, "R7 no allocate", 32'(rd_cnt - r0), 8);
    wt_mode = 1'b0;
  endtask

  task automatic t_random;
    logic [31:0] q;
    int r0;
    int bad = 0;
    rand_mode = 1'b1;
    fill_set(4, 1, 65);
    r0 = rd_cnt;
    for (int t = 1; t <= 65; t++) begin
      rd(line(t, 4), q);
      if (q != mval(line(t, 4))) bad++;
    end
    chk(bad == 0, "R9 random mode data", 32'(bad), 0);
    chk(rd_cnt - r0 >= 8, "R9 some line evicted", 32'(rd_cnt - r0), 8);
    rand_mode = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_miss_hit();
    t_wb_write();
    t_evict_low_rr();
    t_evict_high();
    t_wt();
    t_random();
    chk(hold_bad == 0, "R10 beat held until ack", 32'(hold_bad), 0);
    chk(pulse_bad == 0, "R11 ready single pulse", 32'(pulse_bad), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule